// File: doc/BRIEF.md
# One-Time-Programmable Fuse Auto-Read Sequencer

This block sits between a simple register bus and a one-time-programmable fuse macro. Software writes a word address and a request bit into an auto-control register. The block then plays out a timed access on the macro pins: chip-select, program-enable, load, the address bus and strobe. It captures the 32-bit word the macro presents and raises a finish flag, which software clears by writing a one to it. The array holds 32 words of 32 bits. The address field is 10 bits wide, so the block does not limit the address to the populated range.

Each macro pin has its own window of the form [start, end), counted in clock cycles from the first cycle of the access. There are two sets of five windows, one for read accesses and one for program accesses, so software sets the pin timing and no fixed state machine does. An access lasts as many cycles as the largest end value in the set it uses. A mode bit can hand the pins to direct software control instead.

Top module: `fuse_autoread_seq`

## Requirements
- R1: After reset the pins idle in standby (fz_cs_n=1, fz_pgm_n=1, fz_load=0, fz_strobe=0, fz_addr=0) and fin_flag=0. The control register at 0x00 reads 0x0000_0018. The auto-control register at 0x24 reads 0. Each timing register at 0x28+4*i (program set) and 0x3C+4*i (read set) reads {start[31:16], end[15:0]}, where i=0 chip-select, 1 program-enable, 2 load, 3 address, 4 strobe. The read defaults are 0..11, 0..11, 0..11, 2..10 and 5..8. The program defaults are 0..1130 for the first four and 110..1110 for strobe.
- R2: While an access runs, in the cycle whose counter value is k, a pin is active exactly when start <= k < end for its window. Active means fz_cs_n=0, fz_pgm_n=0, fz_load=1 or fz_strobe=1.
- R3: An access whose set has largest end value E lasts max(E,1) cycles. Bit 0 of 0x24 reads 1 throughout the access and returns to 0 when it ends.
- R4: In the cycle after an access ends, fin_flag and bit 0 of 0x18 are 1. Writing 1 to bit 0 of 0x18 clears the flag, and writing 0 leaves it unchanged. If a clearing write falls on the edge where an access ends, the flag stays set.
- R5: A read access stores into 0x20 the macro data sampled on its final clock edge. A program access leaves 0x20 unchanged.
- R6: While an access runs, writes to 0x00, 0x24 and the timing registers have no effect.
- R7: A write to 0x24 with bit 0 set starts an access. Bit 1 selects the read window set (1) or the program window set (0).
- R8: When bit 0 of 0x00 is 1 (direct mode), the pins follow 0x00: bit 1 strobe, bit 2 load, bit 3 program-enable pin level, bit 4 chip-select pin level, bits 25:16 address. In this mode writes to 0x24 start nothing.
- R9: During the address window fz_addr carries bits 25:16 of the starting write to 0x24, and outside it fz_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset, used for both read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| fz_cs_n | output | 1 | Macro chip-select, active low |
| fz_pgm_n | output | 1 | Macro program-enable, active low |
| fz_load | output | 1 | Macro load, active high |
| fz_addr | output | 10 | Macro word address |
| fz_strobe | output | 1 | Macro strobe, active high |
| fz_dout | input | 32 | Macro data output |
| fin_flag | output | 1 | Access-finished flag (mirror of 0x18 bit 0) |

## Verification
Read accesses run at the default timing at several word addresses, including 0x3FF, and each shows the captured word. A reprogrammed read set with an empty window, a window longer than the others and a window that ends before strobe confirms that each pin follows only its own window. An all-zero set shows the one-cycle minimum length. A long program access shows that the window set is chosen by bit 1 and that the data register holds its value. Writes issued mid-access, a clearing write timed onto the final edge, and requests made in direct mode tell the ignored cases apart from the accepted ones.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int NPIN  = 5;
  localparam int FLD_W = 16;

  localparam int PIN_CS = 0;
  localparam int PIN_PG = 1;
  localparam int PIN_LD = 2;
  localparam int PIN_AD = 3;
  localparam int PIN_ST = 4;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h18;
  localparam logic [7:0] OFS_DOUT = 8'h20;
  localparam logic [7:0] OFS_AUTO = 8'h24;
  localparam logic [7:0] OFS_TPRG = 8'h28;
  localparam logic [7:0] OFS_TRD  = 8'h3C;

  typedef struct packed {
    logic [FLD_W-1:0] on;
    logic [FLD_W-1:0] off;
  } fz_win_t;

  function automatic fz_win_t def_win(input bit rd, input int idx);
    fz_win_t w;
    if (rd) begin
      case (idx)
        PIN_AD:  begin w.on = 16'd2; w.off = 16'd10; end
        PIN_ST:  begin w.on = 16'd5; w.off = 16'd8;  end
        default: begin w.on = 16'd0; w.off = 16'd11; end
      endcase
    end else begin
      if (idx == PIN_ST) begin w.on = 16'd110; w.off = 16'd1110; end
      else               begin w.on = 16'd0;   w.off = 16'd1130; end
    end
    return w;
  endfunction
endpackage

// File: rtl/fz_window.sv
module fz_window
  import fz_pkg::*;
(
  input  logic [FLD_W-1:0] cnt,
  input  fz_win_t          win_rd,
  input  fz_win_t          win_pg,
  input  logic             sel_rd,
  output logic             active
);
  fz_win_t w;
  always_comb begin
    w      = sel_rd ? win_rd : win_pg;
    active = (cnt >= w.on) && (cnt < w.off);
  end
endmodule

// File: rtl/fz_regfile.sv
module fz_regfile
  import fz_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int BUS_AW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wen,
  input  logic [BUS_AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  busy,
  input  logic                  finish,
  input  logic [DATA_W-1:0]     dout,
  output fz_win_t [NPIN-1:0]    rd_win,
  output fz_win_t [NPIN-1:0]    pg_win,
  output logic                  user_mode,
  output logic                  user_cs_n,
  output logic                  user_pg_n,
  output logic                  user_load,
  output logic                  user_strobe,
  output logic [ADDR_W-1:0]     user_addr,
  output logic                  flag,
  output logic                  start,
  output logic                  start_rd,
  output logic [ADDR_W-1:0]     start_addr
);
  localparam int AF_LO = 16;

  logic [4:0]        ctrl_bits_q;
  logic [ADDR_W-1:0] ctrl_addr_q;
  logic              flag_q;
  logic              auto_rd_q;
  logic [ADDR_W-1:0] auto_addr_q;
  fz_win_t [NPIN-1:0] rd_q, pg_q;

  logic wr_ctrl, wr_auto, w1c;
  always_comb begin
    wr_ctrl    = bus_wen && !busy && (bus_addr == BUS_AW'(OFS_CTRL));
    wr_auto    = bus_wen && !busy && (bus_addr == BUS_AW'(OFS_AUTO));
    w1c        = bus_wen && (bus_addr == BUS_AW'(OFS_STAT)) && bus_wdata[0];
    start      = wr_auto && bus_wdata[0] && !ctrl_bits_q[0];
    start_rd   = bus_wdata[1];
    start_addr = bus_wdata[AF_LO +: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_bits_q <= 5'b11000;
      ctrl_addr_q <= '0;
      flag_q      <= 1'b0;
      auto_rd_q   <= 1'b0;
      auto_addr_q <= '0;
      for (int i = 0; i < NPIN; i++) begin
        rd_q[i] <= def_win(1'b1, i);
        pg_q[i] <= def_win(1'b0, i);
      end
    end else begin
      if (wr_ctrl) begin
        ctrl_bits_q <= bus_wdata[4:0];
        ctrl_addr_q <= bus_wdata[AF_LO +: ADDR_W];
      end
      if (start) begin
        auto_rd_q   <= start_rd;
        auto_addr_q <= start_addr;
      end
      if (finish)   flag_q <= 1'b1;
      else if (w1c) flag_q <= 1'b0;
      if (bus_wen && !busy) begin
        for (int i = 0; i < NPIN; i++) begin
          if (bus_addr == BUS_AW'(OFS_TPRG + 8'(4 * i))) pg_q[i] <= bus_wdata;
          if (bus_addr == BUS_AW'(OFS_TRD  + 8'(4 * i))) rd_q[i] <= bus_wdata;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      BUS_AW'(OFS_CTRL): begin
        bus_rdata[4:0]               = ctrl_bits_q;
        bus_rdata[AF_LO +: ADDR_W]   = ctrl_addr_q;
      end
      BUS_AW'(OFS_STAT): bus_rdata[0] = flag_q;
      BUS_AW'(OFS_DOUT): bus_rdata    = dout;
      BUS_AW'(OFS_AUTO): begin
        bus_rdata[0]                 = busy;
        bus_rdata[1]                 = auto_rd_q;
        bus_rdata[AF_LO +: ADDR_W]   = auto_addr_q;
      end
      default: begin
        for (int i = 0; i < NPIN; i++) begin
          if (bus_addr == BUS_AW'(OFS_TPRG + 8'(4 * i))) bus_rdata = pg_q[i];
          if (bus_addr == BUS_AW'(OFS_TRD  + 8'(4 * i))) bus_rdata = rd_q[i];
        end
      end
    endcase
  end

  assign rd_win      = rd_q;
  assign pg_win      = pg_q;
  assign user_mode   = ctrl_bits_q[0];
  assign user_strobe = ctrl_bits_q[1];
  assign user_load   = ctrl_bits_q[2];
  assign user_pg_n   = ctrl_bits_q[3];
  assign user_cs_n   = ctrl_bits_q[4];
  assign user_addr   = ctrl_addr_q;
  assign flag        = flag_q;
endmodule

// File: rtl/fz_seq.sv
module fz_seq
  import fz_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_rd,
  input  logic [ADDR_W-1:0]  start_addr,
  input  fz_win_t [NPIN-1:0] rd_win,
  input  fz_win_t [NPIN-1:0] pg_win,
  input  logic [DATA_W-1:0]  mac_dout,
  output logic               busy,
  output logic               finish,
  output logic [DATA_W-1:0]  dout,
  output logic               p_cs_n,
  output logic               p_pg_n,
  output logic               p_load,
  output logic [ADDR_W-1:0]  p_addr,
  output logic               p_strobe
);
  logic [FLD_W-1:0]  cnt_q, len_q, nxt_cnt, len_c;
  logic              busy_q, rd_q, last, sel_rd, load_pins;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q;
  logic [NPIN-1:0]   act;

  always_comb begin
    last      = busy_q && (cnt_q == len_q - 1'b1);
    nxt_cnt   = start ? '0 : cnt_q + 1'b1;
    sel_rd    = start ? start_rd : rd_q;
    load_pins = start || (busy_q && !last);
    len_c     = '0;
    for (int i = 0; i < NPIN; i++) begin
      if (start_rd) begin
        if (rd_win[i].off > len_c) len_c = rd_win[i].off;
      end else begin
        if (pg_win[i].off > len_c) len_c = pg_win[i].off;
      end
    end
    if (len_c == '0) len_c = FLD_W'(1);
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_win
    fz_window u_win (
      .cnt    (nxt_cnt),
      .win_rd (rd_win[g]),
      .win_pg (pg_win[g]),
      .sel_rd (sel_rd),
      .active (act[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      len_q    <= FLD_W'(1);
      rd_q     <= 1'b0;
      addr_q   <= '0;
      dout_q   <= '0;
      p_cs_n   <= 1'b1;
      p_pg_n   <= 1'b1;
      p_load   <= 1'b0;
      p_addr   <= '0;
      p_strobe <= 1'b0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        len_q  <= len_c;
        rd_q   <= start_rd;
        addr_q <= start_addr;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      cnt_q  <= nxt_cnt;
      end
      if (last && rd_q) dout_q <= mac_dout;
      if (load_pins) begin
        p_cs_n   <= ~act[PIN_CS];
        p_pg_n   <= ~act[PIN_PG];
        p_load   <= act[PIN_LD];
        p_addr   <= act[PIN_AD] ? (start ? start_addr : addr_q) : '0;
        p_strobe <= act[PIN_ST];
      end else begin
        p_cs_n   <= 1'b1;
        p_pg_n   <= 1'b1;
        p_load   <= 1'b0;
        p_addr   <= '0;
        p_strobe <= 1'b0;
      end
    end
  end

  assign busy   = busy_q;
  assign finish = last;
  assign dout   = dout_q;
endmodule

// File: rtl/fuse_autoread_seq.sv
module fuse_autoread_seq
  import fz_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fz_cs_n,
  output logic              fz_pgm_n,
  output logic              fz_load,
  output logic [ADDR_W-1:0] fz_addr,
  output logic              fz_strobe,
  input  logic [DATA_W-1:0] fz_dout,
  output logic              fin_flag
);
  fz_win_t [NPIN-1:0] rd_win, pg_win;
  logic              seq_busy, seq_finish, user_mode;
  logic              u_cs_n, u_pg_n, u_load, u_strobe;
  logic [ADDR_W-1:0] u_addr, s_addr;
  logic              s_cs_n, s_pg_n, s_load, s_strobe;
  logic              start, start_rd;
  logic [ADDR_W-1:0] start_addr;
  logic [DATA_W-1:0] dout_w;

  fz_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_AW(BUS_AW)) u_regs (
    .clk, .rst, .bus_wen, .bus_addr, .bus_wdata, .bus_rdata,
    .busy(seq_busy), .finish(seq_finish), .dout(dout_w),
    .rd_win, .pg_win, .user_mode,
    .user_cs_n(u_cs_n), .user_pg_n(u_pg_n), .user_load(u_load),
    .user_strobe(u_strobe), .user_addr(u_addr), .flag(fin_flag),
    .start, .start_rd, .start_addr
  );

  fz_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk, .rst, .start, .start_rd, .start_addr, .rd_win, .pg_win,
    .mac_dout(fz_dout), .busy(seq_busy), .finish(seq_finish), .dout(dout_w),
    .p_cs_n(s_cs_n), .p_pg_n(s_pg_n), .p_load(s_load), .p_addr(s_addr),
    .p_strobe(s_strobe)
  );

  always_comb begin
    fz_cs_n   = user_mode ? u_cs_n   : s_cs_n;
    fz_pgm_n  = user_mode ? u_pg_n   : s_pg_n;
    fz_load   = user_mode ? u_load   : s_load;
    fz_addr   = user_mode ? u_addr   : s_addr;
    fz_strobe = user_mode ? u_strobe : s_strobe;
  end
endmodule

// File: rtl/fuse_autoread_chk.sv
module fuse_autoread_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              finish,
  input logic              user_mode,
  input logic              fin_flag,
  input logic [DATA_W-1:0] dout,
  input logic              fz_cs_n,
  input logic              fz_pgm_n,
  input logic              fz_load,
  input logic [ADDR_W-1:0] fz_addr,
  input logic              fz_strobe
);
  a_r4_flag_after_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> fin_flag);

  a_r5_dout_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(dout));

  a_r8_direct_never_busy: assert property (@(posedge clk) disable iff (rst)
    user_mode |-> !busy);

  a_r1_idle_standby: assert property (@(posedge clk) disable iff (rst)
    (!busy && !user_mode) |-> (fz_cs_n && fz_pgm_n && !fz_load && !fz_strobe && (fz_addr == '0)));

  a_r3_finish_ends: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy);
endmodule

bind fuse_autoread_seq fuse_autoread_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(seq_busy), .finish(seq_finish),
  .user_mode(user_mode), .fin_flag(fin_flag), .dout(dout_w),
  .fz_cs_n(fz_cs_n), .fz_pgm_n(fz_pgm_n), .fz_load(fz_load),
  .fz_addr(fz_addr), .fz_strobe(fz_strobe)
);

// File: tb/fuse_autoread_seq_tb.sv
`timescale 1ns/1ps
module fuse_autoread_seq_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        b_wen = 0;
  logic [7:0]  b_addr = 0;
  logic [31:0] b_wdata = 0;
  logic [31:0] b_rdata;
  logic        fz_cs_n, fz_pgm_n, fz_load, fz_strobe, fin_flag;
  logic [9:0]  fz_addr;
  logic [31:0] fz_dout = 0;

  always #2.5 clk = ~clk;

  fuse_autoread_seq u_dut (
    .clk, .rst, .bus_wen(b_wen), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_rdata(b_rdata), .fz_cs_n, .fz_pgm_n, .fz_load, .fz_addr, .fz_strobe,
    .fz_dout, .fin_flag
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state; set 0 = program timing, 1 = read timing
  int ws[2][5], we[2][5];
  int mcnt, mlen, mset;
  bit mbusy, mrd, mflag;
  logic [9:0]  maddr;
  logic [31:0] mctrl, mdout, mac, mmac;

  function automatic logic [31:0] h(input logic [9:0] a);
    return 32'hA5C3_0000 ^ ({22'b0, a} * 32'h0001_0F1D);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 5; i++) begin
        ws[s][i] = 0; we[s][i] = (s == 1) ? 11 : 1130;
      end
    ws[1][3] = 2; we[1][3] = 10; ws[1][4] = 5; we[1][4] = 8;
    ws[0][4] = 110; we[0][4] = 1110;
    mcnt = 0; mlen = 1; mset = 0; mbusy = 0; mrd = 0; mflag = 0;
    maddr = 0; mctrl = 32'h18; mdout = 0; mmac = 0;
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      bit fin, was;
      fin = 0; was = mbusy;
      if (mbusy) begin
        if (mcnt == mlen - 1) begin
          mbusy = 0; fin = 1;
          if (mrd) mdout = mmac;
        end else mcnt++;
      end
      if (b_wen && !was) begin
        if (b_addr == 8'h00) mctrl = b_wdata & 32'h03FF_001F;
        else if (b_addr == 8'h24 && b_wdata[0] && !mctrl[0]) begin
          mrd = b_wdata[1]; maddr = b_wdata[25:16]; mset = mrd ? 1 : 0;
          mlen = 0;
          for (int i = 0; i < 5; i++) if (we[mset][i] > mlen) mlen = we[mset][i];
          if (mlen == 0) mlen = 1;
          mbusy = 1; mcnt = 0;
        end else
          for (int i = 0; i < 5; i++) begin
            if (b_addr == 8'(8'h28 + 4*i)) begin ws[0][i] = b_wdata[31:16]; we[0][i] = b_wdata[15:0]; end
            if (b_addr == 8'(8'h3C + 4*i)) begin ws[1][i] = b_wdata[31:16]; we[1][i] = b_wdata[15:0]; end
          end
      end
      if (fin) mflag = 1;
      else if (b_wen && b_addr == 8'h18 && b_wdata[0]) mflag = 0;
    end
  end

  function automatic bit act(input int i);
    return (mcnt >= ws[mset][i]) && (mcnt < we[mset][i]);
  endfunction

  // per-cycle pin comparison (R2, R9, R8, R1) and fuse macro model
  always @(negedge clk) begin
    if (!rst) begin
      logic e_cs, e_pg, e_ld, e_st;
      logic [9:0] e_ad;
      if (mbusy) begin
        e_cs = !act(0); e_pg = !act(1); e_ld = act(2); e_st = act(4);
        e_ad = act(3) ? maddr : 10'd0;
      end else if (mctrl[0]) begin
        e_st = mctrl[1]; e_ld = mctrl[2]; e_pg = mctrl[3]; e_cs = mctrl[4]; e_ad = mctrl[25:16];
      end else begin
        e_cs = 1; e_pg = 1; e_ld = 0; e_st = 0; e_ad = 0;
      end
      chk({fz_cs_n, fz_pgm_n, fz_load, fz_strobe, fz_addr} === {e_cs, e_pg, e_ld, e_st, e_ad},
          "R2/R9 pins", {18'b0, fz_cs_n, fz_pgm_n, fz_load, fz_strobe, fz_addr},
          {18'b0, e_cs, e_pg, e_ld, e_st, e_ad});
      chk(fin_flag === mflag, "R4 fin_flag", {31'b0, fin_flag}, {31'b0, mflag});
      if (e_st) mmac = h(e_ad);
    end
    if (fz_strobe === 1'b1) mac = h(fz_addr);
    fz_dout = mac;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); b_wen = 1; b_addr = a; b_wdata = d;
    @(negedge clk); b_wen = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); b_wen = 0; b_addr = a; #1;
    chk(b_rdata === exp, req, b_rdata, exp);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (mbusy && g < 70000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset values
    rd_chk(8'h00, 32'h0000_0018, "R1 ctrl reset");
    rd_chk(8'h18, 32'h0, "R1 status reset");
    rd_chk(8'h24, 32'h0, "R1 auto reset");
    rd_chk(8'h4C, 32'h0005_0008, "R1 read strobe timing");
    rd_chk(8'h48, 32'h0002_000A, "R1 read addr timing");
    rd_chk(8'h38, 32'h006E_0456, "R1 program strobe timing");
    rd_chk(8'h28, 32'h0000_046A, "R1 program cs timing");

    // R7 read access, default timing
    wr(8'h24, (32'd5 << 16) | 32'h3);
    rd_chk(8'h24, (32'd5 << 16) | 32'h3, "R3 auto busy bit");
    wait_idle();
    rd_chk(8'h24, (32'd5 << 16) | 32'h2, "R3 auto-enable cleared");
    rd_chk(8'h18, 32'h1, "R4 flag set");
    rd_chk(8'h20, h(10'd5), "R5 dout addr 5");

    // R4 write-one-to-clear
    wr(8'h18, 32'h0);
    rd_chk(8'h18, 32'h1, "R4 write 0 keeps flag");
    wr(8'h18, 32'h1);
    rd_chk(8'h18, 32'h0, "R4 W1C clears");

    // R6 writes during access ignored
    wr(8'h24, (32'd7 << 16) | 32'h3);
    wr(8'h24, (32'd9 << 16) | 32'h3);
    wr(8'h4C, 32'h0001_0002);
    wr(8'h00, 32'h0000_0001);
    wait_idle();
    rd_chk(8'h20, h(10'd7), "R6 dout from first request");
    rd_chk(8'h4C, 32'h0005_0008, "R6 timing unchanged");
    rd_chk(8'h00, 32'h0000_0018, "R6 ctrl unchanged");
    wr(8'h18, 32'h1);

    // R7 program access uses program set; R5 dout held
    wr(8'h24, (32'd3 << 16) | 32'h1);
    repeat (600) @(negedge clk);
    rd_chk(8'h24, (32'd3 << 16) | 32'h1, "R7 program access still busy");
    wait_idle();
    rd_chk(8'h20, h(10'd7), "R5 program keeps dout");
    rd_chk(8'h18, 32'h1, "R3 flag after program");
    wr(8'h18, 32'h1);

    // R2 custom read timing, R9 top address
    wr(8'h3C, 32'h0000_0006);
    wr(8'h40, 32'h0002_0002);
    wr(8'h44, 32'h0003_0014);
    wr(8'h48, 32'h0000_0004);
    wr(8'h4C, 32'h0001_0003);
    wr(8'h24, (32'h3FF << 16) | 32'h3);
    wait_idle();
    rd_chk(8'h20, h(10'h3FF), "R9 dout addr 0x3FF");

    // R3 all-zero ends => one-cycle access
    for (int i = 0; i < 5; i++) wr(8'(8'h3C + 4*i), 32'h0);
    wr(8'h18, 32'h1);
    wr(8'h24, (32'd12 << 16) | 32'h3);
    rd_chk(8'h18, 32'h1, "R3 one-cycle access done");
    rd_chk(8'h20, h(10'h3FF), "R5 no strobe keeps macro data");

    // R4 clear on final edge loses to set
    wr(8'h3C, 32'h0000_000B);
    wr(8'h40, 32'h0000_000B);
    wr(8'h44, 32'h0000_000B);
    wr(8'h48, 32'h0002_000A);
    wr(8'h4C, 32'h0005_0008);
    wr(8'h18, 32'h1);
    wr(8'h24, (32'd31 << 16) | 32'h3);
    repeat (10) @(negedge clk);
    b_wen = 1; b_addr = 8'h18; b_wdata = 32'h1;
    @(negedge clk); b_wen = 0;
    rd_chk(8'h18, 32'h1, "R4 set wins over clear");
    rd_chk(8'h20, h(10'd31), "R5 dout addr 31");

    // R8 direct mode
    wr(8'h00, (32'h155 << 16) | 32'h0000_000F);
    @(negedge clk);
    chk({fz_cs_n, fz_pgm_n, fz_load, fz_strobe, fz_addr} === {1'b0, 1'b1, 1'b1, 1'b1, 10'h155},
        "R8 direct pins", {18'b0, fz_cs_n, fz_pgm_n, fz_load, fz_strobe, fz_addr},
        {18'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h155});
    wr(8'h18, 32'h1);
    wr(8'h24, (32'd2 << 16) | 32'h3);
    rd_chk(8'h24, (32'd31 << 16) | 32'h2, "R8 request ignored");
    repeat (15) @(negedge clk);
    rd_chk(8'h18, 32'h0, "R8 no finish in direct mode");
    wr(8'h00, 32'h0000_0018);
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule